// File: doc/BRIEF.md
# DRAM Bank Page-Policy Command Selector

This block is the per-bank decision engine of a DRAM controller. Each cycle it looks at the request the scheduler presents for its bank and names the one DRAM command that request needs next: open a row, close the row, or issue a column access with or without auto-precharge. It remembers whether the bank is precharged or has a row open, and which row that is. The choice follows one of four page policies selected at run time: open, closed, open-adaptive and closed-adaptive.

The scheduler supplies two lookahead hints: whether other requests are queued for this bank, and whether any of them targets the currently open row. The adaptive policies use these hints to decide between a plain column command, which leaves the row open, and an auto-precharge column command, which closes it. Timing-constraint checking lives outside the block and arrives as a single ready input. Refresh and power management likewise live outside and appear only as `hold_i` (blocked) and `doze_i` (sleeping).

The bank state machine has two states, PRECHARGED and ACTIVATED. The named transitions are OPEN_ROW (PRECHARGED to ACTIVATED on an issued ACT, latching the row) and CLOSE_ROW (ACTIVATED to PRECHARGED on an issued PRE, RDA or WRA). An issued RD or WR keeps the bank ACTIVATED with the same row. Any other cycle holds the state.

Top module: `bank_cmd_selector`

## Requirements
- R1: After reset the bank is PRECHARGED, `cmd_o` is NOP (code 0) and `err_o` is 0.
- R2: `cmd_o` is NOP whenever `doze_i` is 1, `hold_i` is 1, `req_valid_i` is 0 or `timing_ok_i` is 0. When `doze_i`, `hold_i` or a missing request causes the NOP, `err_o` is also 0.
- R3: In PRECHARGED, a valid request of any kind yields ACT (code 1). An issued ACT moves the bank to ACTIVATED with `req_row_i` as its open row.
- R4: Open policy (`policy_i`=0), ACTIVATED: a row hit yields RD (code 3) for a read or WR (code 4) for a write, and a row miss yields PRE (code 2). Request kinds: 1 = read, 2 = write.
- R5: Closed policy (`policy_i`=1), ACTIVATED: every request yields RDA (code 5) for a read or WRA (code 6) for a write, whatever its row.
- R6: Open-adaptive policy (`policy_i`=2), ACTIVATED: a row hit yields RDA/WRA when `more_pend_i`=1 and `more_hit_i`=0, and RD/WR otherwise. A row miss yields PRE.
- R7: Closed-adaptive policy (`policy_i`=3), ACTIVATED: a row hit yields RD/WR when `more_hit_i`=1, and RDA/WRA otherwise.
- R8: Closed-adaptive policy, ACTIVATED, row miss: `err_o`=1 and `cmd_o`=NOP. This happens whether or not `timing_ok_i` is set.
- R9: An issued PRE, RDA or WRA returns the bank to PRECHARGED. An issued RD or WR keeps the row open, so a later request to the same row is again a hit.
- R10: In ACTIVATED, when a column command is needed and the request kind is 0 or 3, `err_o`=1, `cmd_o`=NOP and the bank state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Page policy: 0 open, 1 closed, 2 open-adaptive, 3 closed-adaptive |
| req_valid_i | input | 1 | A request is pending for this bank |
| req_row_i | input | ROW_W | Row address of the pending request |
| req_kind_i | input | 2 | Request kind: 1 read, 2 write, others illegal |
| more_pend_i | input | 1 | Further requests are queued for this bank |
| more_hit_i | input | 1 | A further queued request hits the open row |
| doze_i | input | 1 | Bank is sleeping |
| hold_i | input | 1 | Bank is blocked |
| timing_ok_i | input | 1 | Timing constraints allow the chosen command now |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR, 5 RDA, 6 WRA |
| err_o | output | 1 | Illegal request for the current state and policy |

## Verification
The decision and the state update collide in a single cycle. The command chosen in a cycle is also what moves the bank between states at that cycle's edge, so an incorrect state transition shows up one cycle later as an incorrect hit/miss decision. The bench drives long random runs over a small row set, with the timing-ready input often low, changing policies and stray illegal request kinds. Many cycles therefore carry a command that was decided but not issued, or an error, and neither of these may move the bank. Every cycle, a behavioural model that tracks state and open row compares its command and error against the outputs. Directed sequences cover each policy's hit, miss and hint combinations.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

    typedef enum logic [1:0] {
        POL_OPEN         = 2'd0,
        POL_CLOSED       = 2'd1,
        POL_OPEN_ADAPT   = 2'd2,
        POL_CLOSED_ADAPT = 2'd3
    } page_pol_e;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RDA = 3'd5,
        CMD_WRA = 3'd6
    } dram_cmd_e;

    typedef enum logic {
        ST_PRECHARGED = 1'b0,
        ST_ACTIVATED  = 1'b1
    } bank_st_e;

    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;

endpackage

// File: rtl/bank_state_reg.sv
module bank_state_reg
    import bank_sel_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dram_cmd_e        cmd_i,
    input  logic [ROW_W-1:0] row_i,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] open_row_o
);

    bank_st_e         state_n;
    logic [ROW_W-1:0] row_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o    <= ST_PRECHARGED;
            open_row_o <= '0;
        end else begin
            state_o    <= state_n;
            open_row_o <= row_n;
        end
    end

    always_comb begin
        state_n = state_o;
        row_n   = open_row_o;
        unique case (state_o)
            ST_PRECHARGED: begin
                if (cmd_i == CMD_ACT) begin      // OPEN_ROW
                    state_n = ST_ACTIVATED;
                    row_n   = row_i;
                end
            end
            ST_ACTIVATED: begin
                if (cmd_i == CMD_PRE || cmd_i == CMD_RDA || cmd_i == CMD_WRA)
                    state_n = ST_PRECHARGED;     // CLOSE_ROW
            end
            default: state_n = ST_PRECHARGED;
        endcase
    end

endmodule

// File: rtl/bank_cmd_decide.sv
module bank_cmd_decide
    import bank_sel_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  page_pol_e        policy_i,
    input  logic             valid_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [1:0]       kind_i,
    input  logic             more_pend_i,
    input  logic             more_hit_i,
    input  logic             doze_i,
    input  logic             hold_i,
    input  logic             timing_ok_i,
    input  bank_st_e         state_i,
    input  logic [ROW_W-1:0] open_row_i,
    output dram_cmd_e        cmd_o,
    output logic             err_o
);

    dram_cmd_e want;
    logic      bad;
    logic      col;
    logic      auto_pre;
    logic      hit;

    assign hit = (row_i == open_row_i);

    always_comb begin
        want     = CMD_NOP;
        bad      = 1'b0;
        col      = 1'b0;
        auto_pre = 1'b0;
        if (valid_i && !doze_i && !hold_i) begin
            unique case (state_i)
                ST_PRECHARGED: want = CMD_ACT;
                ST_ACTIVATED: begin
                    unique case (policy_i)
                        POL_OPEN: begin
                            if (hit) col = 1'b1;
                            else     want = CMD_PRE;
                        end
                        POL_CLOSED: begin
                            col      = 1'b1;
                            auto_pre = 1'b1;
                        end
                        POL_OPEN_ADAPT: begin
                            if (hit) begin
                                col      = 1'b1;
                                auto_pre = more_pend_i && !more_hit_i;
                            end else begin
                                want = CMD_PRE;
                            end
                        end
                        POL_CLOSED_ADAPT: begin
                            if (hit) begin
                                col      = 1'b1;
                                auto_pre = !more_hit_i;
                            end else begin
                                bad = 1'b1;
                            end
                        end
                        default: bad = 1'b1;
                    endcase
                    if (col) begin
                        if (kind_i == KIND_READ)
                            want = auto_pre ? CMD_RDA : CMD_RD;
                        else if (kind_i == KIND_WRITE)
                            want = auto_pre ? CMD_WRA : CMD_WR;
                        else
                            bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
        end
    end

    always_comb begin
        err_o = bad;
        cmd_o = (timing_ok_i && !bad) ? want : CMD_NOP;
    end

endmodule

// File: rtl/bank_cmd_selector.sv
module bank_cmd_selector
    import bank_sel_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic             req_valid_i,
    input  logic [ROW_W-1:0] req_row_i,
    input  logic [1:0]       req_kind_i,
    input  logic             more_pend_i,
    input  logic             more_hit_i,
    input  logic             doze_i,
    input  logic             hold_i,
    input  logic             timing_ok_i,
    output logic [2:0]       cmd_o,
    output logic             err_o
);

    bank_st_e         bank_st;
    logic [ROW_W-1:0] open_row;
    dram_cmd_e        cmd_w;
    page_pol_e        pol_w;

    assign pol_w = page_pol_e'(policy_i);
    assign cmd_o = cmd_w;

    bank_cmd_decide #(.ROW_W(ROW_W)) u_decide (
        .policy_i    (pol_w),
        .valid_i     (req_valid_i),
        .row_i       (req_row_i),
        .kind_i      (req_kind_i),
        .more_pend_i (more_pend_i),
        .more_hit_i  (more_hit_i),
        .doze_i      (doze_i),
        .hold_i      (hold_i),
        .timing_ok_i (timing_ok_i),
        .state_i     (bank_st),
        .open_row_i  (open_row),
        .cmd_o       (cmd_w),
        .err_o       (err_o)
    );

    bank_state_reg #(.ROW_W(ROW_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_w),
        .row_i      (req_row_i),
        .state_o    (bank_st),
        .open_row_o (open_row)
    );

    AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_i || hold_i || !req_valid_i || !timing_ok_i) |-> cmd_w == CMD_NOP); // R2

    AST_ACT_FROM_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_ACT) |-> bank_st == ST_PRECHARGED); // R3

    AST_ROW_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_ACT) |=> (bank_st == ST_ACTIVATED && open_row == $past(req_row_i))); // R3

    AST_CLOSED_NO_PLAIN_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_w == POL_CLOSED) |-> (cmd_w != CMD_RD && cmd_w != CMD_WR)); // R5

    AST_CLOSE_TO_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_PRE || cmd_w == CMD_RDA || cmd_w == CMD_WRA) |=> bank_st == ST_PRECHARGED); // R9

    AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> ($stable(bank_st) && $stable(open_row))); // R10

endmodule

// File: tb/tb_bank_cmd_selector.sv
`timescale 1ns/1ps
module tb_bank_cmd_selector;

    localparam int ROW_W = 14;
    localparam int C_NOP = 0, C_ACT = 1, C_PRE = 2, C_RD = 3, C_WR = 4, C_RDA = 5, C_WRA = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       policy_i = '0;
    logic             req_valid_i = 1'b0;
    logic [ROW_W-1:0] req_row_i = '0;
    logic [1:0]       req_kind_i = '0;
    logic             more_pend_i = 1'b0;
    logic             more_hit_i = 1'b0;
    logic             doze_i = 1'b0;
    logic             hold_i = 1'b0;
    logic             timing_ok_i = 1'b0;
    logic [2:0]       cmd_o;
    logic             err_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_open = 0;
    int m_row = 0;

    always #2.5 clk = ~clk;

    bank_cmd_selector #(.ROW_W(ROW_W)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(output int ec, output bit ee, output string tag);
        bit rd, wr, hit, autop, colreq;
        ec = C_NOP; ee = 0; tag = "R2"; colreq = 0; autop = 0;
        rd  = (req_kind_i == 2'd1);
        wr  = (req_kind_i == 2'd2);
        hit = (int'(req_row_i) == m_row);
        if (!req_valid_i || doze_i || hold_i) return;
        if (m_open == 0) begin
            ec = C_ACT; tag = "R3";
        end else begin
            case (policy_i)
                2'd0: begin tag = "R4"; if (hit) colreq = 1; else ec = C_PRE; end
                2'd1: begin tag = "R5"; colreq = 1; autop = 1; end
                2'd2: begin tag = "R6"; if (hit) begin colreq = 1; autop = more_pend_i && !more_hit_i; end else ec = C_PRE; end
                default: begin
                    if (hit) begin tag = "R7"; colreq = 1; autop = !more_hit_i; end
                    else begin tag = "R8"; ee = 1; end
                end
            endcase
            if (colreq) begin
                if (rd)      ec = autop ? C_RDA : C_RD;
                else if (wr) ec = autop ? C_WRA : C_WR;
                else begin tag = "R10"; ee = 1; ec = C_NOP; end
            end
        end
        if (!timing_ok_i && !ee) tag = "R2";
        if (!timing_ok_i || ee) ec = C_NOP;
    endtask

    task automatic step(input int pol, input bit v, input int row, input int kind,
                        input bit mp, input bit mh, input bit sl, input bit bl, input bit tok);
        int ec; bit ee; string tag;
        @(negedge clk);
        policy_i = 2'(pol); req_valid_i = v; req_row_i = ROW_W'(row); req_kind_i = 2'(kind);
        more_pend_i = mp; more_hit_i = mh; doze_i = sl; hold_i = bl; timing_ok_i = tok;
        #1;
        model(ec, ee, tag);
        check({tag, " cmd"}, int'(cmd_o), ec);
        check({tag, " err"}, int'(err_o), int'(ee));
        if (ec == C_ACT) begin m_open = 1; m_row = row; end
        else if (ec == C_PRE || ec == C_RDA || ec == C_WRA) m_open = 0;   // R9
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 cmd after reset", int'(cmd_o), C_NOP);
        check("R1 err after reset", int'(err_o), 0);
        // R1/R3: first request after reset sees a precharged bank
        step(0, 1, 5, 1, 0, 0, 0, 0, 1);          // ACT row 5
        // R4 open policy
        step(0, 1, 5, 1, 0, 0, 0, 0, 1);          // RD
        step(0, 1, 5, 2, 0, 0, 0, 0, 1);          // WR, row stays open (R9)
        step(0, 1, 5, 2, 0, 0, 1, 0, 1);          // R2 sleeping
        step(0, 1, 5, 2, 0, 0, 0, 1, 1);          // R2 blocked
        step(0, 1, 7, 1, 0, 0, 0, 0, 0);          // R2 timing not ready
        step(0, 1, 7, 1, 0, 0, 0, 0, 1);          // PRE
        step(0, 1, 7, 0, 0, 0, 0, 0, 1);          // R3 ACT for any kind
        step(0, 1, 7, 3, 0, 0, 0, 0, 1);          // R10 illegal kind
        step(0, 1, 7, 1, 0, 0, 0, 0, 1);          // state unchanged: RD
        // R5 closed
        step(1, 1, 9, 2, 0, 0, 0, 0, 1);          // WRA despite miss
        step(1, 1, 9, 1, 0, 0, 0, 0, 1);          // ACT
        step(1, 1, 9, 1, 1, 1, 0, 0, 1);          // RDA
        // R6 open-adaptive
        step(2, 1, 3, 1, 0, 0, 0, 0, 1);          // ACT
        step(2, 1, 3, 1, 0, 0, 0, 0, 1);          // RD (nothing queued)
        step(2, 1, 3, 2, 1, 1, 0, 0, 1);          // WR (hit queued)
        step(2, 1, 3, 2, 1, 0, 0, 0, 1);          // WRA
        step(2, 1, 4, 1, 0, 0, 0, 0, 1);          // ACT
        step(2, 1, 6, 1, 0, 0, 0, 0, 1);          // PRE on miss
        // R7/R8 closed-adaptive
        step(3, 1, 2, 1, 0, 0, 0, 0, 1);          // ACT
        step(3, 1, 2, 1, 1, 1, 0, 0, 1);          // RD
        step(3, 1, 8, 1, 1, 1, 0, 0, 0);          // R8 miss, timing low
        step(3, 1, 8, 1, 1, 1, 0, 0, 1);          // R8 miss error
        step(3, 1, 2, 2, 0, 0, 0, 0, 1);          // WRA
        // random run against the model
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 3), ($urandom_range(0, 99) < 85), $urandom_range(0, 3),
                 (($urandom_range(0, 99) < 95) ? $urandom_range(1, 2) : ($urandom_range(0, 1) * 3)),
                 $urandom_range(0, 1), $urandom_range(0, 1),
                 ($urandom_range(0, 99) < 8), ($urandom_range(0, 99) < 8),
                 ($urandom_range(0, 99) < 75));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule